// File: doc/BRIEF.md
# Fixed-head disk controller command and status register

This block is the register front end of a fixed-head disk controller. It holds an 18-bit function and status word, a 21-bit starting disk address and an 18-bit data buffer. It decodes processor I/O commands, each formed from a device-group select, a 2-bit subcode and one of three strobes: test, read and write.

The transfer engine sits beside it. The engine watches the `busy` input it owns, reports errors and completion through one-cycle set pulses, and takes the current function, the disk address and one-cycle start and abort strobes from this block. The block folds the error flags into a summary bit and raises the interrupt request and the skip answer from it. While a transfer is running it refuses nearly every register access and flags a programming error instead.

Read data is combinational while a read strobe is high. Every register change lands on the clock edge that samples the strobe.

Top module: `dfh_cmd_regs`

## Requirements
- R1: After reset the status word, disk address and data buffer are zero, and `irq`, `skip`, `start` and `abort` are low.
- R2: Status bit 17 is the error summary. It is set exactly when one of bits 16..10 is set, and it is recomputed on every update. Bits 9, 8 and 7 do not contribute to it. A pulse on `err_set[i]` sets status bit 9+i. A pulse on `done_set` sets bit 7, the done flag.
- R3: The status word is read with group 1, read strobe, subcode 3, and its bits 6..3 always read as zero.
- R4: `irq` is high exactly when the interrupt enable (status bit 0) is set and either the summary bit or the done flag is set.
- R5: Group 0, test strobe, subcode 0 drives `skip` high during the strobe when the summary bit or the done flag is set, and low otherwise. At most one strobe is high in any cycle.
- R6: Group 0, read strobe, subcode 2 XORs `wdata[2:0]` into status bits 2..0. Bits 2..1 are the function (0 no-op, 1 read, 2 write, 3 write-check) and appear on `func`.
- R7: While `busy` is high, every group 0 read or write, the group 0 clear-function command, and the group 1 clear-status and read-status commands set status bit 8 (programming error) instead of acting. Group 0 reads then return zero.
- R8: Group 0 write, subcodes 0 and 1, load the data buffer and the low 18 address bits. Group 0 read, subcodes 0 and 1, return them.
- R9: Group 0 write, subcode 3, loads `wdata[2:0]` into address bits 20..18. Group 0 read, subcode 3, returns those bits in bits 2..0, with bit 3 set when the non-existent-disk flag (status bit 10) is set.
- R10: Loading the high address bits so that the full address is at or above NUM_DISKS*2^18 sets the non-existent-disk flag.
- R11: Group 0 write, subcode 2, clears the done flag. When the function is non-zero it also makes `start` high for the one cycle after the sampling edge.
- R12: Group 0, test strobe, subcode 1 clears the status word, the address and the buffer, and pulses `abort` for one cycle. It acts even while busy.
- R13: Group 0, test strobe, subcode 2 clears the function and interrupt-enable bits.
- R14: Group 1, read strobe, subcode 2 clears the whole status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp | input | 1 | Command group select (0 main, 1 secondary) |
| sub | input | 2 | Command subcode |
| stb_test | input | 1 | Test strobe |
| stb_rd | input | 1 | Read strobe |
| stb_wr | input | 1 | Write strobe |
| wdata | input | 18 | Command write data |
| busy | input | 1 | Transfer in progress, from the engine |
| err_set | input | 8 | Error set pulses for status bits 16..9 |
| done_set | input | 1 | Completion set pulse |
| rdata | output | 18 | Read data, valid during a read strobe |
| skip | output | 1 | Skip answer to the test command |
| irq | output | 1 | Interrupt request |
| start | output | 1 | One-cycle start strobe to the engine |
| abort | output | 1 | One-cycle abort strobe to the engine |
| func | output | 2 | Current function code |
| disk_addr | output | 21 | Starting disk address |

## Verification
The assertions assume that the command strobes are one-hot or idle in every cycle, and that `busy` does not fall in the same cycle as a command the checks look at. The bench issues every command through one task that raises exactly one strobe for a single cycle. It changes `busy` only between commands, and it pulses the engine inputs only when no command is in flight. Under these rules the checks on status reads, on start provenance and on programming-error capture stay within what the design promises.

// File: rtl/dfh_cmd_regs.sv
module dfh_cmd_regs #(
  parameter int NUM_DISKS = 1,
  parameter int DW        = 18,
  parameter int AW        = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp,
  input  logic [1:0]    sub,
  input  logic          stb_test,
  input  logic          stb_rd,
  input  logic          stb_wr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic [7:0]    err_set,
  input  logic          done_set,
  output logic [DW-1:0] rdata,
  output logic          skip,
  output logic          irq,
  output logic          start,
  output logic          abort,
  output logic [1:0]    func,
  output logic [AW-1:0] disk_addr
);
  localparam int HW = AW - DW;
  localparam logic [AW:0] CAPACITY = (AW+1)'(NUM_DISKS) << DW;

  logic [16:0]   sta_q, sta_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] buf_q, buf_n;
  logic          start_n, abort_n;

  wire g0      = ~grp;
  wire t_skip  = stb_test & g0 & (sub == 2'd0);
  wire t_clr   = stb_test & g0 & (sub == 2'd1);
  wire t_clrfn = stb_test & g0 & (sub == 2'd2);
  wire r0      = stb_rd & g0;
  wire w0      = stb_wr & g0;
  wire r1_clr  = stb_rd & grp & (sub == 2'd2);
  wire r1_sta  = stb_rd & grp & (sub == 2'd3);
  wire pge_hit = busy & (r0 | w0 | t_clrfn | r1_clr | r1_sta);

  wire summary = |sta_q[16:10];
  wire [DW-1:0] status_word = {summary, sta_q[16:7], 4'b0000, sta_q[2:0]};
  wire [AW:0]   hi_probe = {1'b0, wdata[HW-1:0], addr_q[DW-1:0]};

  assign func      = sta_q[2:1];
  assign disk_addr = addr_q;
  assign irq       = sta_q[0] & (summary | sta_q[7]);
  assign skip      = t_skip & (summary | sta_q[7]);

  always_comb begin
    rdata = '0;
    if (r1_sta) rdata = status_word;
    else if (r0 && !busy) begin
      case (sub)
        2'd0: rdata = buf_q;
        2'd1: rdata = addr_q[DW-1:0];
        2'd3: rdata = DW'({sta_q[10], addr_q[AW-1:DW]});
        default: rdata = '0;
      endcase
    end
  end

  always_comb begin
    sta_n   = sta_q;
    addr_n  = addr_q;
    buf_n   = buf_q;
    start_n = 1'b0;
    abort_n = 1'b0;
    if (t_clr) begin
      sta_n   = '0;
      addr_n  = '0;
      buf_n   = '0;
      abort_n = 1'b1;
    end else begin
      if (pge_hit) sta_n[8] = 1'b1;
      else begin
        if (t_clrfn) sta_n[2:0] = 3'b000;
        if (r1_clr) sta_n = '0;
        if (r0 && sub == 2'd2) sta_n[2:0] = sta_q[2:0] ^ wdata[2:0];
        if (w0) begin
          case (sub)
            2'd0: buf_n = wdata;
            2'd1: addr_n[DW-1:0] = wdata;
            2'd2: begin
              sta_n[7] = 1'b0;
              start_n  = |sta_q[2:1];
            end
            default: begin
              addr_n[AW-1:DW] = wdata[HW-1:0];
              if (hi_probe >= CAPACITY) sta_n[10] = 1'b1;
            end
          endcase
        end
      end
      sta_n[16:9] = sta_n[16:9] | err_set;
      sta_n[7]    = sta_n[7] | done_set;
    end
    sta_n[6:3] = 4'b0000;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_q  <= '0;
      addr_q <= '0;
      buf_q  <= '0;
      start  <= 1'b0;
      abort  <= 1'b0;
    end else begin
      sta_q  <= sta_n;
      addr_q <= addr_n;
      buf_q  <= buf_n;
      start  <= start_n;
      abort  <= abort_n;
    end
  end

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_test, stb_rd, stb_wr}));

  assert_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    r1_sta |-> (rdata[17] == |rdata[16:10]));

  assert_gap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    r1_sta |-> (rdata[6:3] == 4'b0000));

  assert_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    r1_sta |-> (irq == (rdata[0] & (rdata[17] | rdata[7]))));

  assert_busy_pge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && w0) |=> (sta_q[8] && $stable(buf_q) && $stable(addr_q)));

  assert_start_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(w0 && sub == 2'd2 && !busy));

  assert_abort_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (addr_q == '0 && buf_q == '0 && !start));
endmodule

// File: tb/tb_dfh_cmd_regs.sv
`timescale 1ns/1ps
module tb_dfh_cmd_regs;
  logic clk = 0, rst_n = 0;
  logic grp = 0, stb_test = 0, stb_rd = 0, stb_wr = 0, busy = 0, done_set = 0;
  logic [1:0] sub = 0;
  logic [17:0] wdata = 0;
  logic [7:0] err_set = 0;
  logic [17:0] rdata;
  logic skip, irq, start, abort;
  logic [1:0] func;
  logic [20:0] disk_addr;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [17:0] c_rd;
  logic c_skip, c_start, c_abort;

  always #2.5 clk = ~clk;

  dfh_cmd_regs dut (.clk(clk), .rst_n(rst_n), .grp(grp), .sub(sub),
    .stb_test(stb_test), .stb_rd(stb_rd), .stb_wr(stb_wr), .wdata(wdata),
    .busy(busy), .err_set(err_set), .done_set(done_set), .rdata(rdata),
    .skip(skip), .irq(irq), .start(start), .abort(abort), .func(func),
    .disk_addr(disk_addr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // kind: 0 test, 1 read, 2 write
  task automatic cmd(input logic g, input int kind, input logic [1:0] s, input logic [17:0] d);
    @(negedge clk);
    grp = g; sub = s; wdata = d;
    stb_test = (kind == 0); stb_rd = (kind == 1); stb_wr = (kind == 2);
    #1 c_rd = rdata; c_skip = skip;
    @(posedge clk);
    #1 c_start = start; c_abort = abort;
    stb_test = 0; stb_rd = 0; stb_wr = 0; wdata = 0;
  endtask

  task automatic engine(input logic [7:0] e, input logic d);
    @(negedge clk); err_set = e; done_set = d;
    @(posedge clk); #1 err_set = 0; done_set = 0;
  endtask

  task automatic rd_status(output logic [17:0] v);
    cmd(1, 1, 2'd3, 0); v = c_rd;
  endtask

  task automatic t_reset;
    logic [17:0] v;
    check("R1 irq", irq, 0); check("R1 start", start, 0); check("R1 abort", abort, 0);
    rd_status(v); check("R1 status", v, 0);
    cmd(0, 0, 2'd0, 0); check("R1 skip", c_skip, 0);
    cmd(0, 1, 2'd0, 0); check("R1 buffer", c_rd, 0);
  endtask

  task automatic t_regs;
    cmd(0, 2, 2'd0, 18'h25A5A); cmd(0, 1, 2'd0, 0); check("R8 buffer", c_rd, 18'h25A5A);
    cmd(0, 2, 2'd1, 18'h12345); cmd(0, 1, 2'd1, 0); check("R8 addr low", c_rd, 18'h12345);
    cmd(0, 2, 2'd3, 18'h0); cmd(0, 1, 2'd3, 0); check("R9 addr high", c_rd, 0);
    check("R8 disk_addr", disk_addr, 21'h012345);
  endtask

  task automatic t_func;
    logic [17:0] v;
    cmd(0, 1, 2'd2, 18'h3); check("R6 func read", func, 1);
    check("R4 irq idle", irq, 0);
    cmd(0, 1, 2'd2, 18'h6); check("R6 func xor", func, 2);
    rd_status(v); check("R6 status bits", v, 18'h5);
  endtask

  task automatic t_start;
    logic [17:0] v;
    cmd(0, 2, 2'd2, 0); check("R11 start pulse", c_start, 1);
    @(posedge clk); #1 check("R11 start one cycle", start, 0);
    engine(8'h00, 1);
    check("R4 irq done", irq, 1);
    cmd(0, 0, 2'd0, 0); check("R5 skip done", c_skip, 1);
    rd_status(v); check("R2 done no summary", v, 18'h85);
    cmd(0, 2, 2'd2, 0); rd_status(v); check("R11 done cleared", v, 18'h05);
    engine(8'h00, 1);
  endtask

  task automatic t_busy;
    logic [17:0] v;
    busy = 1;
    cmd(0, 2, 2'd2, 0); check("R7 no start", c_start, 0);
    cmd(0, 2, 2'd0, 18'h00111);
    cmd(0, 1, 2'd0, 0); check("R7 read zero", c_rd, 0);
    cmd(0, 0, 2'd2, 0);
    busy = 0;
    cmd(0, 1, 2'd0, 0); check("R7 buffer kept", c_rd, 18'h25A5A);
    rd_status(v); check("R7 pge func kept", v, 18'h185);
  endtask

  task automatic t_clrfn;
    logic [17:0] v;
    cmd(0, 0, 2'd2, 0); check("R13 func", func, 0);
    check("R4 irq no enable", irq, 0);
    rd_status(v); check("R13 status", v, 18'h180);
  endtask

  task automatic t_errors;
    logic [17:0] v;
    engine(8'h10, 0); rd_status(v); check("R2 write-check summary", v, 18'h22180);
    cmd(1, 1, 2'd2, 0); rd_status(v); check("R14 clear status", v, 0);
    engine(8'h01, 0); rd_status(v); check("R2 timing no summary", v, 18'h200);
    cmd(0, 0, 2'd0, 0); check("R5 skip low", c_skip, 0);
    cmd(0, 1, 2'd2, 18'h1); engine(8'h40, 0);
    check("R4 irq error", irq, 1);
    cmd(0, 0, 2'd0, 0); check("R5 skip error", c_skip, 1);
    cmd(1, 1, 2'd2, 0); check("R14 irq cleared", irq, 0);
  endtask

  task automatic t_ned;
    logic [17:0] v;
    cmd(0, 2, 2'd1, 18'h5); cmd(0, 2, 2'd3, 18'h0);
    rd_status(v); check("R10 in range", v, 0);
    cmd(0, 2, 2'd3, 18'h1);
    rd_status(v); check("R10 ned set", v, 18'h20400);
    cmd(0, 1, 2'd3, 0); check("R9 high with ned", c_rd, 18'h9);
    check("R9 disk_addr", disk_addr, 21'h040005);
  endtask

  task automatic t_clrall;
    logic [17:0] v;
    cmd(0, 1, 2'd2, 18'h4);
    busy = 1;
    cmd(0, 0, 2'd1, 0); check("R12 abort", c_abort, 1);
    busy = 0;
    check("R12 func", func, 0);
    cmd(0, 1, 2'd0, 0); check("R12 buffer", c_rd, 0);
    cmd(0, 1, 2'd1, 0); check("R12 addr", c_rd, 0);
    rd_status(v); check("R12 status", v, 0);
    cmd(0, 2, 2'd2, 0); check("R11 no start when no-op", c_start, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset(); t_regs(); t_func(); t_start(); t_busy();
    t_clrfn(); t_errors(); t_ned(); t_clrall();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule